// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block gathers single-cycle event pulses from sixteen peripheral sources and four non-maskable trap inputs, stores each event in a sticky pending bit, and offers one winning request at a time to a processor. Every maskable source carries a two-bit priority code that either disables it or places it in one of three levels. Level 3 outranks level 2, which outranks level 1. Inside a level the lower source index wins. Traps skip both the mask and the global enable, always outrank maskable work, and have a fixed order of their own.

The processor sees a request line, a trap flag and a source index. The index is captured into a holding register and stays put while the request line is high, until the processor pulses acknowledge. Acknowledge clears the pending bit it served and drops the global enable. Software reaches the pending bits, the global enable and the priority codes through a small address/write-enable/data port whose writes take effect on the next clock edge. The global enable also falls on a disable-interrupts strobe, a trap-instruction strobe, any trap event, and reset.

Top module: `irq_ctl`

## Requirements
- R1: A one-cycle pulse on `src_pulse_i[i]` sets pending bit i at the next rising edge. Pending bit i is bit i of the word at address 0. It stays set until an acknowledge or a software clear.
- R2: Source i has a 2-bit priority code at bits [2*(i mod 8)+1 : 2*(i mod 8)] of the word at address 2 + i/8. Code 00 disables the source, 01 selects level 1, 10 level 2 and 11 level 3. A pending but disabled source never raises `irq_o`.
- R3: When several enabled requests are pending, a higher level wins over a lower one, whatever their indices.
- R4: Among pending requests at the same level, the lowest source index wins.
- R5: For a maskable source, `irq_o` is high only while the global enable (bit 0 of address 1) is set and an enabled request is pending. The winner appears two rising edges after its pulse, or one edge after the global enable is set.
- R6: A pulse on `trap_pulse_i[k]` raises `irq_o` with `irq_trap_o`=1 and `irq_idx_o`=k. This happens regardless of the global enable and the priority codes, and the trap beats any maskable request. Lower k wins: 0 reset, 1 watchdog, 2 oscillator fail, 3 illegal instruction.
- R7: `irq_ack_i` high while `irq_o` is high clears the served pending bit (maskable or trap) and the global enable at that edge.
- R8: A software write to address 0 clears every pending bit whose data bit is 0. Data bits that are 1 have no effect.
- R9: If a source pulse and a clear of the same bit (acknowledge or software write) happen in the same cycle, the bit ends up set.
- R10: The global enable is set only by writing 1 to bit 0 of address 1. It is cleared by writing 0 there, by `di_i`, by `trap_instr_i`, by any trap pulse and by acknowledge.
- R11: While `irq_o` stays high and no acknowledge is given, `irq_idx_o` and `irq_trap_o` do not change, even when a higher-priority request arrives.
- R12: Reset clears all pending bits, all priority codes, the global enable and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_pulse_i | input | 16 | One-cycle event pulses from maskable sources |
| trap_pulse_i | input | 4 | One-cycle trap events (reset, watchdog, oscillator fail, illegal instruction) |
| di_i | input | 1 | Disable-interrupts strobe |
| trap_instr_i | input | 1 | Trap-instruction strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address: 0 pending, 1 control, 2 and 3 priority codes |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Request to the processor |
| irq_trap_o | output | 1 | Presented request is a trap |
| irq_idx_o | output | 4 | Index of the presented source or trap |
| irq_ack_i | input | 1 | Processor acknowledge |

## Verification
The bench builds the block with its default parameters: sixteen maskable sources, four traps and a 16-bit data word. These values give two priority words, so sources on both sides of the word split (index 7 against index 8) can be tested in a single arbitration. With four traps, two simultaneous traps can be served one after the other, and a trap can arrive while a maskable request is pending. With a 2-bit address, all four registers can be read back directly, which makes every clear, set and no-effect case visible at the ports.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_OFF = 2'b00;
  localparam lvl_t LVL_TOP = 2'b11;
  localparam int unsigned ADDR_REQ   = 0;
  localparam int unsigned ADDR_CTRL  = 1;
  localparam int unsigned ADDR_PRIO0 = 2;
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         wr_en_i,
  input  logic [N-1:0] wr_keep_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_d;

  always_comb begin
    q_d = q_o & ~clr_i;
    if (wr_en_i) q_d = q_d & wr_keep_i;
    q_d = q_d | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R1
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && clr_i == '0) |=> ((q_o & $past(q_o)) == $past(q_o)));
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned DW    = 16,
  localparam int unsigned PER  = DW / 2,
  localparam int unsigned N_PW = (N_SRC + PER - 1) / PER,
  localparam int unsigned WW   = (N_PW > 1) ? $clog2(N_PW) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [WW-1:0]              word_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [DW-1:0]              rdata_o,
  output irq_pkg::lvl_t [N_SRC-1:0]  lvl_o
);
  logic [N_PW-1:0][DW-1:0] prio_q;

  for (genvar w = 0; w < N_PW; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                            prio_q[w] <= '0;
      else if (we_i && word_i == WW'(w))      prio_q[w] <= wdata_i;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_lvl
    assign lvl_o[i] = prio_q[i / PER][(i % PER) * 2 +: 2];
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < N_PW; w++)
      if (word_i == WW'(w)) rdata_o = prio_q[w];
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input  logic [N-1:0]          req_i,
  input  irq_pkg::lvl_t [N-1:0] lvl_i,
  output logic                  vld_o,
  output logic [IW-1:0]         idx_o,
  output irq_pkg::lvl_t         lvl_o
);
  import irq_pkg::*;

  // descending scan with >= lets the lower index take ties
  always_comb begin
    lvl_o = LVL_OFF;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && lvl_i[i] != LVL_OFF && lvl_i[i] >= lvl_o) begin
        lvl_o = lvl_i[i];
        idx_o = IW'(i);
      end
    end
    vld_o = (lvl_o != LVL_OFF);
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && lvl_i[i] != LVL_OFF) begin
        // R3
        level_order_chk: assert (vld_o && lvl_i[i] <= lvl_o) else $error("higher level lost");
        // R4
        index_order_chk: assert (!(lvl_i[i] == lvl_o && i < int'(idx_o))) else $error("lower index lost");
      end
    end
  end
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned N_TRAP = 4,
  parameter int unsigned DW     = N_SRC,
  localparam int unsigned IW    = $clog2(N_SRC),
  localparam int unsigned TW    = (N_TRAP > 1) ? $clog2(N_TRAP) : 1,
  localparam int unsigned PER   = DW / 2,
  localparam int unsigned N_PW  = (N_SRC + PER - 1) / PER,
  localparam int unsigned WW    = (N_PW > 1) ? $clog2(N_PW) : 1,
  localparam int unsigned AW    = $clog2(2 + N_PW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_pulse_i,
  input  logic [N_TRAP-1:0] trap_pulse_i,
  input  logic              di_i,
  input  logic              trap_instr_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o,
  output logic              irq_trap_o,
  output logic [IW-1:0]     irq_idx_o,
  input  logic              irq_ack_i
);
  import irq_pkg::*;

  logic [N_SRC-1:0]  req_q, src_clr, req_gated;
  logic [N_TRAP-1:0] trap_q, trap_clr;
  lvl_t [N_SRC-1:0]  lvl;
  lvl_t [N_TRAP-1:0] trap_lvl;
  logic [DW-1:0]     prio_rdata;
  logic [AW-1:0]     pw_off;
  logic              wr_req, wr_ctrl, wr_prio, ack_fire, ge_q, ge_clr;
  logic              m_vld, t_vld, hold_ok;
  logic [IW-1:0]     m_idx, t_idx;
  lvl_t              m_lvl, t_lvl;
  logic              hold_vld_q, hold_trap_q;
  logic [IW-1:0]     hold_idx_q;

  assign wr_req  = reg_we_i && reg_addr_i == AW'(ADDR_REQ);
  assign wr_ctrl = reg_we_i && reg_addr_i == AW'(ADDR_CTRL);
  assign wr_prio = reg_we_i && reg_addr_i >= AW'(ADDR_PRIO0);
  assign pw_off  = reg_addr_i - AW'(ADDR_PRIO0);

  assign ack_fire = irq_o && irq_ack_i;
  assign src_clr  = (ack_fire && !hold_trap_q) ? (N_SRC'(1) << hold_idx_q) : '0;
  assign trap_clr = (ack_fire && hold_trap_q) ? (N_TRAP'(1) << hold_idx_q[TW-1:0]) : '0;

  irq_req_bank #(.N(N_SRC)) u_src_bank (
    .clk_i, .rst_ni,
    .set_i     (src_pulse_i),
    .clr_i     (src_clr),
    .wr_en_i   (wr_req),
    .wr_keep_i (reg_wdata_i[N_SRC-1:0]),
    .q_o       (req_q)
  );

  irq_req_bank #(.N(N_TRAP)) u_trap_bank (
    .clk_i, .rst_ni,
    .set_i     (trap_pulse_i),
    .clr_i     (trap_clr),
    .wr_en_i   (1'b0),
    .wr_keep_i ('1),
    .q_o       (trap_q)
  );

  irq_prio_regs #(.N_SRC(N_SRC), .DW(DW)) u_prio (
    .clk_i, .rst_ni,
    .we_i    (wr_prio),
    .word_i  (pw_off[WW-1:0]),
    .wdata_i (reg_wdata_i),
    .rdata_o (prio_rdata),
    .lvl_o   (lvl)
  );

  // global enable: clear events beat a set in the same cycle
  assign ge_clr = di_i || trap_instr_i || (|trap_pulse_i) || ack_fire
               || (wr_ctrl && !reg_wdata_i[0]);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                        ge_q <= 1'b0;
    else if (ge_clr)                    ge_q <= 1'b0;
    else if (wr_ctrl && reg_wdata_i[0]) ge_q <= 1'b1;

  assign req_gated = req_q & {N_SRC{ge_q}};

  irq_arbiter #(.N(N_SRC), .IW(IW)) u_src_arb (
    .req_i (req_gated), .lvl_i (lvl),
    .vld_o (m_vld), .idx_o (m_idx), .lvl_o (m_lvl)
  );

  for (genvar k = 0; k < N_TRAP; k++) begin : g_trap_lvl
    assign trap_lvl[k] = LVL_TOP;
  end

  irq_arbiter #(.N(N_TRAP), .IW(IW)) u_trap_arb (
    .req_i (trap_q), .lvl_i (trap_lvl),
    .vld_o (t_vld), .idx_o (t_idx), .lvl_o (t_lvl)
  );

  // held winner stays valid only while its source still qualifies
  always_comb begin
    if (hold_trap_q) hold_ok = trap_q[hold_idx_q[TW-1:0]];
    else             hold_ok = ge_q && req_q[hold_idx_q] && lvl[hold_idx_q] != LVL_OFF;
  end

  assign irq_o      = hold_vld_q && hold_ok;
  assign irq_trap_o = hold_trap_q;
  assign irq_idx_o  = hold_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hold_vld_q  <= 1'b0;
      hold_trap_q <= 1'b0;
      hold_idx_q  <= '0;
    end else if (ack_fire) begin
      hold_vld_q  <= 1'b0;
    end else if (!irq_o) begin
      hold_vld_q  <= t_vld || m_vld;
      hold_trap_q <= t_vld;
      hold_idx_q  <= t_vld ? t_idx : m_idx;
    end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == AW'(ADDR_REQ))       reg_rdata_o[N_SRC-1:0] = req_q;
    else if (reg_addr_i == AW'(ADDR_CTRL)) reg_rdata_o[0] = ge_q;
    else                                   reg_rdata_o = prio_rdata;
  end

  // R5
  mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_trap_o) |-> (ge_q && req_q[irq_idx_o]));

  // R7
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_ack_i) |=> !ge_q);

  // R10
  ge_set_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ge_q) |-> $past(wr_ctrl && reg_wdata_i[0]));

  // R11
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> (!irq_o || ($stable(irq_idx_o) && $stable(irq_trap_o))));

  // R6
  trap_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !irq_ack_i && trap_q != '0) |=> irq_trap_o);
endmodule

// File: tb/irq_ctl_tb.sv
module irq_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] src = '0;
  logic [3:0]  trap = '0;
  logic        di = 1'b0, tins = 1'b0, we = 1'b0, ack = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0, rdata, rv;
  logic        irq, irq_trap;
  logic [3:0]  idx;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  irq_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_pulse_i(src), .trap_pulse_i(trap),
    .di_i(di), .trap_instr_i(tins), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .irq_trap_o(irq_trap), .irq_idx_o(idx), .irq_ack_i(ack)
  );

  typedef struct packed {
    logic [15:0] lo;
    logic [15:0] hi;
    logic [15:0] pulse;
    logic        vld;
    logic [3:0]  idx;
  } vec_t;

  // priority words, pulses, expected request and winner (R2 R3 R4)
  localparam vec_t VEC [7] = '{
    '{16'hAAAA, 16'hAAAA, 16'h0030, 1'b1, 4'd4},
    '{16'h5555, 16'hFFFF, 16'h0101, 1'b1, 4'd8},
    '{16'hAAAA, 16'h5555, 16'h8002, 1'b1, 4'd1},
    '{16'h0000, 16'hAAAA, 16'h00FF, 1'b0, 4'd0},
    '{16'h00C0, 16'hFFFF, 16'h8008, 1'b1, 4'd3},
    '{16'h5555, 16'h5555, 16'hC000, 1'b1, 4'd14},
    '{16'hAAA9, 16'h0000, 16'h0005, 1'b1, 4'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_src(input logic [15:0] m);
    @(negedge clk); src = m;
    @(negedge clk); src = '0;
  endtask

  task automatic pulse_trap(input logic [3:0] m);
    @(negedge clk); trap = m;
    @(negedge clk); trap = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    // R12 reset state
    chk("R12 irq at reset", irq, 0);
    rd(0, rv); chk("R12 pending at reset", rv, 0);
    rd(1, rv); chk("R12 enable at reset", rv, 0);
    rd(2, rv); chk("R12 prio at reset", rv, 0);
    @(negedge clk); rst_ni = 1'b1;

    foreach (VEC[v]) begin
      wr(0, 16'h0000);
      wr(2, VEC[v].lo);
      wr(3, VEC[v].hi);
      wr(1, 16'h0001);
      pulse_src(VEC[v].pulse);
      @(negedge clk);
      chk($sformatf("R2 R3 R4 vector %0d irq", v), irq, VEC[v].vld);
      if (VEC[v].vld) begin
        chk($sformatf("R3 R4 vector %0d idx", v), idx, VEC[v].idx);
        chk($sformatf("R5 vector %0d trap flag", v), irq_trap, 0);
      end
    end

    // R1 latch and hold; R2 disabled source stays silent
    wr(0, 16'h0000); wr(1, 16'h0000); wr(2, 16'h0000); wr(3, 16'h0000);
    pulse_src(16'h0040);
    rd(0, rv); chk("R1 pending latched", rv, 16'h0040);
    wr(1, 16'h0001);
    repeat (3) @(negedge clk);
    chk("R2 disabled source no irq", irq, 0);
    rd(0, rv); chk("R1 pending sticky", rv, 16'h0040);
    wr(1, 16'h0000);

    // R8 software write semantics
    wr(0, 16'hFFFF);
    rd(0, rv); chk("R8 write one no effect", rv, 16'h0040);
    wr(0, 16'hFFBF);
    rd(0, rv); chk("R8 write zero clears", rv, 16'h0000);

    // R5 gating by global enable
    wr(2, 16'h0403);
    pulse_src(16'h0020);
    @(negedge clk);
    chk("R5 enable off no irq", irq, 0);
    wr(1, 16'h0001);
    @(negedge clk);
    chk("R5 enable on irq", irq, 1);
    chk("R5 enable on idx", idx, 5);

    // R11 no preemption while presented
    pulse_src(16'h0001);
    @(negedge clk); @(negedge clk);
    chk("R11 held irq", irq, 1);
    chk("R11 held idx", idx, 5);

    // R7 acknowledge
    do_ack();
    chk("R7 irq after ack", irq, 0);
    rd(1, rv); chk("R7 enable after ack", rv, 0);
    rd(0, rv); chk("R7 pending after ack", rv, 16'h0001);
    wr(1, 16'h0001);
    @(negedge clk);
    chk("R3 next winner idx", idx, 0);
    chk("R3 next winner irq", irq, 1);

    // R9 set beats acknowledge clear
    @(negedge clk); ack = 1'b1; src = 16'h0001;
    @(negedge clk); ack = 1'b0; src = '0;
    rd(0, rv); chk("R9 pulse vs ack", rv, 16'h0001);
    // R9 set beats software clear
    @(negedge clk); we = 1'b1; addr = 2'd0; wdata = 16'h0000; src = 16'h0080;
    @(negedge clk); we = 1'b0; src = '0;
    rd(0, rv); chk("R9 pulse vs write", rv, 16'h0080);

    // R6 traps bypass enable, fixed order
    wr(0, 16'h0000);
    pulse_trap(4'b1100);
    @(negedge clk);
    chk("R6 trap irq", irq, 1);
    chk("R6 trap flag", irq_trap, 1);
    chk("R6 trap order first", idx, 2);
    do_ack();
    @(negedge clk);
    chk("R6 trap order second", idx, 3);
    chk("R6 second trap flag", irq_trap, 1);
    do_ack();
    @(negedge clk);
    chk("R6 traps drained", irq, 0);

    // R6 trap beats maskable; R10 trap clears enable
    wr(2, 16'h0003);
    wr(1, 16'h0001);
    @(negedge clk); src = 16'h0001; trap = 4'b0010;
    @(negedge clk); src = '0; trap = '0;
    @(negedge clk);
    chk("R6 trap over maskable flag", irq_trap, 1);
    chk("R6 trap over maskable idx", idx, 1);
    rd(1, rv); chk("R10 trap clears enable", rv, 0);
    do_ack();

    // R10 enable set and clear sources
    wr(1, 16'h0001);
    rd(1, rv); chk("R10 write one sets", rv, 1);
    @(negedge clk); di = 1'b1;
    @(negedge clk); di = 1'b0;
    rd(1, rv); chk("R10 di clears", rv, 0);
    wr(1, 16'h0001);
    @(negedge clk); tins = 1'b1;
    @(negedge clk); tins = 1'b0;
    rd(1, rv); chk("R10 trap instruction clears", rv, 0);
    wr(1, 16'h0001);
    wr(1, 16'h0000);
    rd(1, rv); chk("R10 write zero clears", rv, 0);

    // R12 reset mid-run
    wr(1, 16'h0001);
    @(negedge clk);
    chk("R12 irq before reset", irq, 1);
    rst_ni = 1'b0; #1;
    chk("R12 irq in reset", irq, 0);
    rd(0, rv); chk("R12 pending cleared", rv, 0);
    rd(1, rv); chk("R12 enable cleared", rv, 0);
    rd(2, rv); chk("R12 prio cleared", rv, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule